// File: doc/BRIEF.md
# Asynchronous DRAM Device Cycle Decoder Model

This block is a synthesizable stand-in for the device side of an asynchronous, address-multiplexed DRAM. It is meant as the target that memory controller blocks are checked against. The row strobe, column strobe, write strobe, output enable and address are sampled on the system clock. The block works out from the order of their edges what kind of cycle the controller is running, and it reads or writes a small, parameterised cell array to match. The cycle kinds are read, early write, read-modify-write, page-mode column access, row-only refresh, and refresh with the column strobe first.

A 9-bit refresh row counter supplies the row for every refresh that has the column strobe first. Both refresh kinds are reported as a one-clock pulse together with the refreshed row. The data output enable follows the read state and the two live strobes, so a write that begins before the column strobe never drives the bus.

A width monitor counts the row-active, row-precharge and column-active intervals in clocks. It flags any interval shorter than its configured minimum. All outputs are registered and change one clock after the sample that causes them.

Top module: `dram_cycle_model`

## Requirements
- R1: If write strobe is low when the column strobe falls (row strobe low), `din` is stored at the latched row and the column on `addr`, `cycle_kind` becomes 2, and `dout_en` stays 0 for that cycle.
- R2: If write strobe is high when the column strobe falls, the cell is read. The row is the address sampled at the row-strobe fall and the column is the address sampled at the column-strobe fall. One clock later `dout` holds that cell and `cycle_kind` is 1.
- R3: `dout_en` is 1 only in a read, and only while the column strobe and output enable were both sampled low. It returns to 0 one clock after either is sampled high.
- R4: With the row strobe held low, each further column-strobe fall accesses a new column of the same row (page mode), both for reads and for writes.
- R5: If the write strobe falls while read data is being presented, the cycle becomes read-modify-write (`cycle_kind` 3). `dout` keeps the old value and `din` is stored at the same cell.
- R6: A row-strobe low period with no column-strobe fall is a row-only refresh. When the row strobe rises, `ref_pulse` is 1 for one clock with `ref_row` equal to the latched row and `cycle_kind` 4, and `dout_en` stays 0.
- R7: A row-strobe fall while the column strobe is low is a counter refresh. It gives `ref_pulse` with `ref_row` equal to the counter and `cycle_kind` 5. The counter starts at 0 after reset, adds 1 per counter refresh, and wraps from 511 to 0.
- R8: If the column strobe stays low after a read while the row strobe goes high and then low again (hidden refresh), a counter refresh takes place and `dout_en` and `dout` stay unchanged.
- R9: `timing_err` bit 0 flags a row-low interval shorter than RAS_MIN (4 samples). Bit 1 flags a row-high interval shorter than RP_MIN (3). Bit 2 flags a column-low interval shorter than CAS_MIN (2). Each flag is a one-clock pulse after the closing edge is sampled, and legal intervals raise none.
- R10: After reset, `dout_en`, `ref_pulse` and `timing_err` are 0, and `cycle_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data is driven |
| cycle_kind | output | 3 | Last decoded cycle: 0 none, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh |
| ref_pulse | output | 1 | One-clock refresh indication |
| ref_row | output | 9 | Row refreshed with the pulse |
| timing_err | output | 3 | Interval-width violation pulses |

## Verification
The case that needs care is a counter refresh that falls inside a read that is still presenting data. The bench provokes it as a hidden refresh: the column strobe stays low and the output enable stays asserted while the row strobe is raised and lowered again. The check is that exactly one refresh pulse appears with the next counter row, and that the output enable never drops. The scoreboard sees no second rise of the output enable and no change in the data it compared. The read-modify-write case is judged the same way: the old value must still be on `dout` after the write strobe falls, and a later read must return the new value.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

   typedef enum logic [2:0] {
      CK_NONE   = 3'd0,
      CK_READ   = 3'd1,
      CK_EWRITE = 3'd2,
      CK_RMW    = 3'd3,
      CK_ROR    = 3'd4,
      CK_CBR    = 3'd5
   } cyc_kind_t;

   typedef struct packed {
      logic ras_fall;
      logic ras_rise;
      logic cas_fall;
      logic cas_rise;
      logic we_fall;
   } strobe_ev_t;

   localparam int NUM_WIDTH_CHECKS = 3;

endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges
   import dram_model_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   output strobe_ev_t ev
);
   logic ras_q, cas_q, we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cas_q <= 1'b1;
         we_q  <= 1'b1;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
         we_q  <= we_n;
      end
   end

   always_comb begin
      ev.ras_fall = ras_q & ~ras_n;
      ev.ras_rise = ~ras_q & ras_n;
      ev.cas_fall = cas_q & ~cas_n;
      ev.cas_rise = ~cas_q & cas_n;
      ev.we_fall  = we_q & ~we_n;
   end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ROW_BITS = 5,
   parameter int COL_BITS = 5,
   parameter int DATA_W   = 4
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic [ROW_BITS-1:0] wr_row,
   input  logic [COL_BITS-1:0] wr_col,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ROW_BITS-1:0] rd_row,
   input  logic [COL_BITS-1:0] rd_col,
   output logic [DATA_W-1:0]   rd_data
);
   localparam int DEPTH = 1 << (ROW_BITS + COL_BITS);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[{wr_row, wr_col}] <= wr_data;
   end

   assign rd_data = cells[{rd_row, rd_col}];
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
   parameter int REF_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [REF_W-1:0] row
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    row <= '0;
      else if (step) row <= row + 1'b1;
   end
endmodule

// File: rtl/dram_width_mon.sv
module dram_width_mon #(
   parameter int MIN_CYC = 4,
   parameter int CNT_W   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic short_flag
);
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '1;
         prev_q     <= 1'b0;
         short_flag <= 1'b0;
      end else begin
         prev_q     <= active;
         short_flag <= prev_q & ~active & (cnt_q < MIN_V);
         if (active) begin
            if (!prev_q)          cnt_q <= CNT_W'(1);
            else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model
   import dram_model_pkg::*;
#(
   parameter int ROW_BITS = 5,
   parameter int COL_BITS = 5,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 4,
   parameter int REF_W    = 9,
   parameter int RAS_MIN  = 4,
   parameter int RP_MIN   = 3,
   parameter int CAS_MIN  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic [2:0]        cycle_kind,
   output logic              ref_pulse,
   output logic [REF_W-1:0]  ref_row,
   output logic [2:0]        timing_err
);
   localparam int WIDEST = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
   localparam int MAX_MIN = (RAS_MIN > RP_MIN) ?
                            ((RAS_MIN > CAS_MIN) ? RAS_MIN : CAS_MIN) :
                            ((RP_MIN > CAS_MIN) ? RP_MIN : CAS_MIN);
   localparam int CNT_W = $clog2(MAX_MIN + 1) + 1;

   initial begin
      if (ADDR_W != WIDEST)
         $fatal(1, "ADDR_W must equal the wider of ROW_BITS and COL_BITS");
      if (ROW_BITS > REF_W)
         $fatal(1, "ROW_BITS must not exceed REF_W");
      if (RAS_MIN < 1 || RP_MIN < 1 || CAS_MIN < 1)
         $fatal(1, "interval minimums must be positive");
   end

   function automatic int min_for(input int idx);
      case (idx)
         0:       return RAS_MIN;
         1:       return RP_MIN;
         default: return CAS_MIN;
      endcase
   endfunction

   strobe_ev_t ev;

   dram_strobe_edges u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .ev    (ev)
   );

   logic [REF_W-1:0] ctr_row;
   logic             ctr_step;

   dram_refresh_ctr #(.REF_W(REF_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (ctr_step),
      .row   (ctr_row)
   );

   logic [ROW_BITS-1:0] row_q, row_d;
   logic [COL_BITS-1:0] col_q, col_d, wr_col;
   logic                row_open_q, row_open_d;
   logic                col_seen_q, col_seen_d;
   logic                rd_live_q, rd_live_d;
   logic [DATA_W-1:0]   dout_q, dout_d, rd_data;
   logic                dout_en_q, dout_en_d;
   cyc_kind_t           kind_q, kind_d;
   logic                ref_pulse_q, ref_pulse_d;
   logic [REF_W-1:0]    ref_row_q, ref_row_d;
   logic                wr_en;

   dram_cell_array #(
      .ROW_BITS (ROW_BITS),
      .COL_BITS (COL_BITS),
      .DATA_W   (DATA_W)
   ) u_array (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_row  (row_q),
      .wr_col  (wr_col),
      .wr_data (din),
      .rd_row  (row_q),
      .rd_col  (addr[COL_BITS-1:0]),
      .rd_data (rd_data)
   );

   always_comb begin
      row_d       = row_q;
      col_d       = col_q;
      row_open_d  = row_open_q;
      col_seen_d  = col_seen_q;
      rd_live_d   = rd_live_q;
      dout_d      = dout_q;
      kind_d      = kind_q;
      ref_pulse_d = 1'b0;
      ref_row_d   = ref_row_q;
      ctr_step    = 1'b0;
      wr_en       = 1'b0;
      wr_col      = addr[COL_BITS-1:0];

      if (ev.ras_fall) begin
         if (!cas_n) begin
            ref_pulse_d = 1'b1;
            ref_row_d   = ctr_row;
            ctr_step    = 1'b1;
            kind_d      = CK_CBR;
         end else begin
            row_d      = addr[ROW_BITS-1:0];
            row_open_d = 1'b1;
            col_seen_d = 1'b0;
         end
      end

      if (ev.ras_rise) begin
         row_open_d = 1'b0;
         if (row_open_q && !col_seen_q) begin
            ref_pulse_d = 1'b1;
            ref_row_d   = REF_W'(row_q);
            kind_d      = CK_ROR;
         end
      end

      if (ev.cas_fall && row_open_q && !ras_n) begin
         col_d      = addr[COL_BITS-1:0];
         col_seen_d = 1'b1;
         if (!we_n) begin
            wr_en     = 1'b1;
            rd_live_d = 1'b0;
            kind_d    = CK_EWRITE;
         end else begin
            rd_live_d = 1'b1;
            dout_d    = rd_data;
            kind_d    = CK_READ;
         end
      end else if (ev.we_fall && rd_live_q && !cas_n) begin
         wr_en  = 1'b1;
         wr_col = col_q;
         kind_d = CK_RMW;
      end

      if (ev.cas_rise) rd_live_d = 1'b0;

      dout_en_d = rd_live_d & ~cas_n & ~oe_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q       <= '0;
         col_q       <= '0;
         row_open_q  <= 1'b0;
         col_seen_q  <= 1'b0;
         rd_live_q   <= 1'b0;
         dout_q      <= '0;
         dout_en_q   <= 1'b0;
         kind_q      <= CK_NONE;
         ref_pulse_q <= 1'b0;
         ref_row_q   <= '0;
      end else begin
         row_q       <= row_d;
         col_q       <= col_d;
         row_open_q  <= row_open_d;
         col_seen_q  <= col_seen_d;
         rd_live_q   <= rd_live_d;
         dout_q      <= dout_d;
         dout_en_q   <= dout_en_d;
         kind_q      <= kind_d;
         ref_pulse_q <= ref_pulse_d;
         ref_row_q   <= ref_row_d;
      end
   end

   // interval monitors: 0 row low, 1 row high, 2 column low
   logic [NUM_WIDTH_CHECKS-1:0] in_interval;
   assign in_interval = {~cas_n, ras_n, ~ras_n};

   for (genvar gi = 0; gi < NUM_WIDTH_CHECKS; gi++) begin : g_width
      dram_width_mon #(
         .MIN_CYC (min_for(gi)),
         .CNT_W   (CNT_W)
      ) u_mon (
         .clk        (clk),
         .rst_n      (rst_n),
         .active     (in_interval[gi]),
         .short_flag (timing_err[gi])
      );
   end

   assign dout       = dout_q;
   assign dout_en    = dout_en_q;
   assign cycle_kind = kind_q;
   assign ref_pulse  = ref_pulse_q;
   assign ref_row    = ref_row_q;
endmodule

// File: rtl/dram_cycle_model_chk.sv
module dram_cycle_model_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 4,
   parameter int REF_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic              oe_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en,
   input logic [2:0]        cycle_kind,
   input logic              ref_pulse,
   input logic [REF_W-1:0]  ref_row,
   input logic [2:0]        timing_err
);
   logic [REF_W-1:0] shadow_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow_row <= '0;
      else if (ref_pulse && cycle_kind == 3'd5)
         shadow_row <= shadow_row + 1'b1;
   end

   // R1
   early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_kind == 3'd2) |-> !dout_en);

   // R3
   dout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> ($past(!cas_n) && $past(!oe_n)));

   // R5
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_en && $past(dout_en)) |-> $stable(dout));

   // R6
   refresh_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse);

   // R7
   cbr_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse && cycle_kind == 3'd5) |-> (ref_row == shadow_row));

   // R9
   ras_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timing_err[0] |-> ($past(ras_n) && !$past(ras_n, 2)));

   // R9
   cas_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timing_err[2] |-> ($past(cas_n) && !$past(cas_n, 2)));

   // R4
   addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && $past(cas_n) && !ras_n) |-> !$isunknown(addr));

   // R1
   din_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n && !cas_n && !ras_n) |-> !$isunknown(din));
endmodule

bind dram_cycle_model dram_cycle_model_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .REF_W  (REF_W)
) u_chk (.*);

// File: tb/sim_dram_cycle_model.sv
`timescale 1ns/1ps
module sim_dram_cycle_model;
   localparam int DW = 4;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   wire  [DW-1:0] dout;
   wire           dout_en;
   wire  [2:0]    cycle_kind;
   wire           ref_pulse;
   wire  [8:0]    ref_row;
   wire  [2:0]    timing_err;

   dram_cycle_model u0 (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .cycle_kind(cycle_kind), .ref_pulse(ref_pulse), .ref_row(ref_row),
      .timing_err(timing_err)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic          en_prev = 1'b0;
   int            en_rises = 0;
   int            ref_cnt = 0;
   int            ref_last = -1;
   int            ref_kind = -1;
   int            err_cnt [3] = '{0, 0, 0};

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // monitor: pops the scoreboard on each new read presentation
   always @(negedge clk) begin
      if (rst_n) begin
         if (dout_en && !en_prev) begin
            en_rises++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected read data", int'(dout), -1);
            end else begin
               logic [DW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(dout === e, t, int'(dout), int'(e));
            end
         end
         en_prev = dout_en;
         if (ref_pulse) begin
            ref_cnt++;
            ref_last = int'(ref_row);
            ref_kind = int'(cycle_kind);
         end
         for (int b = 0; b < 3; b++) if (timing_err[b]) err_cnt[b]++;
      end
   end

   task automatic step(input logic r, input logic c, input logic w, input logic o,
                       input int a, input int d, input int n);
      @(negedge clk);
      ras_n = r; cas_n = c; we_n = w; oe_n = o;
      addr = AW'(a); din = DW'(d);
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic idle(input int n);
      step(1, 1, 1, 1, 0, 0, n);
   endtask

   task automatic wr_cell(input int row, input int col, input int d);
      step(0, 1, 1, 1, row, 0, 1);
      step(0, 0, 0, 1, col, d, 2);
      step(0, 1, 1, 1, col, 0, 1);
      idle(3);
   endtask

   task automatic rd_cell(input int row, input int col, input int e, input string tag);
      exp_q.push_back(DW'(e)); tag_q.push_back(tag);
      step(0, 1, 1, 1, row, 0, 1);
      step(0, 0, 1, 0, col, 0, 2);
      step(0, 1, 1, 1, col, 0, 1);
      idle(3);
   endtask

   task automatic cbr_cycle();
      step(1, 0, 1, 1, 0, 0, 1);
      step(0, 0, 1, 1, 0, 0, 4);
      idle(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int r0, e0, k0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(4);
      // R10 reset state
      chk(dout_en == 1'b0, "R10 dout_en", int'(dout_en), 0);
      chk(ref_pulse == 1'b0, "R10 ref_pulse", int'(ref_pulse), 0);
      chk(timing_err == 3'b0, "R10 timing_err", int'(timing_err), 0);
      chk(cycle_kind == 3'd0, "R10 cycle_kind", int'(cycle_kind), 0);

      // R1 early write, checked exactly while the column strobe is low
      e0 = en_rises;
      step(0, 1, 1, 1, 3, 0, 1);
      step(0, 0, 0, 1, 5, 10, 2);
      chk(cycle_kind == 3'd2, "R1 kind", int'(cycle_kind), 2);
      chk(dout_en == 1'b0, "R1 output quiet", int'(dout_en), 0);
      step(0, 1, 1, 1, 5, 0, 1);
      idle(3);
      chk(en_rises == e0, "R1 no presentation", en_rises - e0, 0);
      wr_cell(9, 17, 6);

      // R2 reads of distinct cells
      rd_cell(3, 5, 10, "R2 read r3c5");
      rd_cell(9, 17, 6, "R2 read r9c17");
      step(0, 1, 1, 1, 3, 0, 1);
      step(0, 0, 1, 1, 5, 0, 2);
      chk(cycle_kind == 3'd1, "R2 kind", int'(cycle_kind), 1);

      // R3 gating by output enable while the column strobe stays low
      chk(dout_en == 1'b0, "R3 oe high holds off", int'(dout_en), 0);
      exp_q.push_back(DW'(10)); tag_q.push_back("R3 oe late read");
      step(0, 0, 1, 0, 5, 0, 2);
      chk(dout_en == 1'b1, "R3 oe low drives", int'(dout_en), 1);
      step(0, 0, 1, 1, 5, 0, 2);
      chk(dout_en == 1'b0, "R3 oe high releases", int'(dout_en), 0);
      step(0, 1, 1, 1, 5, 0, 1);
      idle(3);

      // R4 page mode writes then page mode reads in one row
      step(0, 1, 1, 1, 20, 0, 1);
      step(0, 0, 0, 1, 1, 11, 2);
      step(0, 1, 1, 1, 1, 0, 1);
      step(0, 0, 0, 1, 2, 12, 2);
      step(0, 1, 1, 1, 2, 0, 1);
      step(0, 0, 0, 1, 31, 13, 2);
      step(0, 1, 1, 1, 31, 0, 1);
      idle(3);
      exp_q.push_back(DW'(12)); tag_q.push_back("R4 page c2");
      exp_q.push_back(DW'(11)); tag_q.push_back("R4 page c1");
      exp_q.push_back(DW'(13)); tag_q.push_back("R4 page c31");
      step(0, 1, 1, 1, 20, 0, 1);
      step(0, 0, 1, 0, 2, 0, 2);
      step(0, 1, 1, 0, 2, 0, 1);
      step(0, 0, 1, 0, 1, 0, 2);
      step(0, 1, 1, 0, 1, 0, 1);
      step(0, 0, 1, 0, 31, 0, 2);
      step(0, 1, 1, 1, 31, 0, 1);
      idle(3);

      // R5 read-modify-write
      exp_q.push_back(DW'(10)); tag_q.push_back("R5 old data");
      step(0, 1, 1, 1, 3, 0, 1);
      step(0, 0, 1, 0, 5, 0, 2);
      step(0, 0, 0, 0, 5, 7, 2);
      chk(cycle_kind == 3'd3, "R5 kind", int'(cycle_kind), 3);
      chk(dout == 4'd10, "R5 old data held", int'(dout), 10);
      step(0, 1, 1, 1, 5, 0, 1);
      idle(3);
      rd_cell(3, 5, 7, "R5 new data stored");

      // R6 row-only refresh
      r0 = ref_cnt; e0 = en_rises;
      step(0, 1, 1, 0, 7, 0, 4);
      idle(3);
      chk(ref_cnt == r0 + 1, "R6 one pulse", ref_cnt - r0, 1);
      chk(ref_last == 7, "R6 row", ref_last, 7);
      chk(ref_kind == 4, "R6 kind", ref_kind, 4);
      chk(en_rises == e0, "R6 output quiet", en_rises - e0, 0);

      // R7 counter refresh
      cbr_cycle();
      chk(ref_last == 0 && ref_kind == 5, "R7 first row", ref_last, 0);
      cbr_cycle();
      chk(ref_last == 1, "R7 second row", ref_last, 1);

      // R8 hidden refresh after a read of r3c5 (now 7)
      r0 = ref_cnt; e0 = en_rises;
      exp_q.push_back(DW'(7)); tag_q.push_back("R8 read before hidden");
      step(0, 1, 1, 1, 3, 0, 1);
      step(0, 0, 1, 0, 5, 0, 3);
      step(1, 0, 1, 0, 5, 0, 3);
      step(0, 0, 1, 0, 5, 0, 4);
      chk(dout_en == 1'b1, "R8 output kept", int'(dout_en), 1);
      chk(dout == 4'd7, "R8 data kept", int'(dout), 7);
      chk(ref_cnt == r0 + 1 && ref_last == 2, "R8 counter row", ref_last, 2);
      chk(en_rises == e0 + 1, "R8 single presentation", en_rises - e0, 1);
      idle(3);

      // R7 wrap of the counter
      for (int i = 3; i < 512; i++) cbr_cycle();
      chk(ref_last == 511, "R7 last row", ref_last, 511);
      cbr_cycle();
      chk(ref_last == 0, "R7 wrap", ref_last, 0);

      // R9 legal traffic so far raised no flag
      k0 = err_cnt[0] + err_cnt[1] + err_cnt[2];
      chk(k0 == 0, "R9 no false flag", k0, 0);
      step(0, 1, 1, 1, 4, 0, 2);
      idle(4);
      chk(err_cnt[0] == 1, "R9 short row low", err_cnt[0], 1);
      step(0, 1, 1, 1, 4, 0, 4);
      step(1, 1, 1, 1, 0, 0, 1);
      step(0, 1, 1, 1, 4, 0, 4);
      idle(4);
      chk(err_cnt[1] == 1, "R9 short precharge", err_cnt[1], 1);
      step(0, 1, 1, 1, 4, 0, 1);
      step(0, 0, 0, 1, 4, 1, 1);
      step(0, 1, 1, 1, 4, 0, 3);
      idle(4);
      chk(err_cnt[2] == 1, "R9 short column", err_cnt[2], 1);
      chk(err_cnt[0] == 1, "R9 row low still clean", err_cnt[0], 1);

      chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule